// File: doc/BRIEF.md
# NAND Bus Timing Cycle Calculator

This block turns a set of flash interface timing limits, given in picoseconds, into the phase lengths, in clock cycles, that an asynchronous memory interface needs when it drives a NAND device. It produces seven phase counts: read setup, read strobe, read hold, bus turnaround, write setup, write strobe and write hold. Each count is stored as the number of cycles minus one, which is the form an interface controller's timing fields expect. The calculation works in signed 32-bit arithmetic throughout.

A host drives the clock period in nanoseconds and seventeen timing limits, then pulses `start`. The block steps through its conversions one at a time over a single shared ceiling divider. It applies the fixed margins for data-input setup (3000 ps) and data-input hold (1600 ps). It then lengthens strobe and hold phases until the whole-access cycle minima are met, and finally registers all phases together with an overflow flag and pulses `done`. The block raises the flag when a result does not fit the narrow timing fields of a typical interface. It takes no other action on out-of-range values.

Top module: `nand_tcyc_calc`

## Requirements
- R1: After reset, `done`, `busy`, `overflow` and every phase output are 0.
- R2: A picosecond value `t` converts to cycles as `cyc(t) = (n + P - 1) / P`, where `n = t / 1000` and `P` is `period_ns`. Both divisions are signed 32-bit and truncate toward zero, so a negative `t` gives a result at or near zero.
- R3: Read setup is `cyc(cle_to_re) - 1`, raised to 0 if negative. Read strobe is `max(cyc(re_access + 3000), cyc(re_pulse)) - 1`, raised to 0 if negative, and then raised to at least `cyc(ce_access + 3000) - 2 - read_setup`.
- R4: Read hold is `cyc(1600 - ce_hiz) - 1`, raised to 0 if negative, and then raised until setup + strobe + hold is at least `cyc(rd_cycle) - 3`.
- R5: Turnaround is `max(cyc(re_hiz - (read_hold + 1) * P * 1000), cyc(ce_hiz)) - 1`, raised to 0 if negative.
- R6: Write setup is `max(cyc(cle_setup), cyc(ale_setup), cyc(ce_setup)) - 1`, raised to 0 if negative. Write strobe is `cyc(we_pulse) - 1`, raised to 0 if negative, and then raised until setup + strobe is at least `cyc(data_setup) - 2`.
- R7: Write hold is the maximum of `cyc(cle_hold)`, `cyc(ale_hold)`, `cyc(ce_hold)` and `cyc(data_hold)`, minus 1, raised to 0 if negative. It is then raised until the three write phases sum to at least `cyc(wr_cycle) - 2`.
- R8: No phase result is ever negative.
- R9: `overflow` is 1 exactly when some phase exceeds its field limit: 15 for the setup and hold phases, 63 for the strobe phases and 3 for turnaround. The phase outputs carry the low bits of each result: 4 bits for setup and hold, 6 for strobe and 2 for turnaround.
- R10: If `start` is high at a clock edge while the block is idle, `busy` is high for the next 18 cycles. `done` then pulses for one cycle, and the new results appear together with it. The results then hold until the next `done`.
- R11: A `start` pulse while `busy` is high is ignored. It causes no extra `done` and does not change the timing of the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| period_ns | input | 16 | Clock period in ns, nonzero |
| cle_to_re_ps | input | 32 | Command latch to read enable delay |
| re_access_ps | input | 32 | Read enable access time |
| re_pulse_ps | input | 32 | Read enable pulse width |
| ce_access_ps | input | 32 | Chip enable access time |
| ce_hiz_ps | input | 32 | Chip enable high to output high impedance |
| rd_cycle_ps | input | 32 | Read cycle time |
| re_hiz_ps | input | 32 | Read enable high to output high impedance |
| cle_setup_ps | input | 32 | Command latch setup |
| ale_setup_ps | input | 32 | Address latch setup |
| ce_setup_ps | input | 32 | Chip enable setup |
| we_pulse_ps | input | 32 | Write enable pulse width |
| data_setup_ps | input | 32 | Data setup |
| cle_hold_ps | input | 32 | Command latch hold |
| ale_hold_ps | input | 32 | Address latch hold |
| ce_hold_ps | input | 32 | Chip enable hold |
| data_hold_ps | input | 32 | Data hold |
| wr_cycle_ps | input | 32 | Write cycle time |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results update |
| rd_setup | output | 4 | Read setup phase |
| rd_strobe | output | 6 | Read strobe phase |
| rd_hold | output | 4 | Read hold phase |
| turnaround | output | 2 | Bus turnaround phase |
| wr_setup | output | 4 | Write setup phase |
| wr_strobe | output | 6 | Write strobe phase |
| wr_hold | output | 4 | Write hold phase |
| overflow | output | 1 | Some phase exceeds its field |

## Verification
The assertions assume that `period_ns` is nonzero whenever a start is accepted. They also assume that the timing inputs stay stable while `busy` is high, because the block reads them step by step instead of latching them. The stimulus sets every input at the falling edge before `start` and keeps it unchanged until `done`, and every vector uses a nonzero period. The inputs are also kept small enough that the turnaround product `(read_hold + 1) * P * 1000` stays within 32 bits. Under these assumptions, the cycle-minimum assertions compare the solved phases with the converted totals only at `done`.

// File: rtl/nand_tcyc_pkg.sv
package nand_tcyc_pkg;

  typedef logic signed [31:0] s32_t;

  localparam int NCONV    = 17;   // conversions stored before the last step
  localparam int NSTEP    = NCONV + 1;
  localparam int SU_MARGIN_PS = 3000;
  localparam int HD_MARGIN_PS = 1600;

  // Index map of the stored conversions; the order is the step order.
  localparam int C_CLR  = 0;
  localparam int C_REA  = 1;
  localparam int C_RP   = 2;
  localparam int C_CEA  = 3;
  localparam int C_RHLD = 4;
  localparam int C_RC   = 5;
  localparam int C_CHZ  = 6;
  localparam int C_CLS  = 7;
  localparam int C_ALS  = 8;
  localparam int C_CS   = 9;
  localparam int C_WP   = 10;
  localparam int C_DS   = 11;
  localparam int C_CLH  = 12;
  localparam int C_ALH  = 13;
  localparam int C_CH   = 14;
  localparam int C_DH   = 15;
  localparam int C_WC   = 16;

  // Truncate to ns, then ceiling-divide by the period (C-style signed).
  function automatic s32_t ps_to_cycles(s32_t ps, s32_t per);
    s32_t ns;
    ns = ps / 32'sd1000;
    if (per == 32'sd0) return 32'sd0;
    return (ns + per - 32'sd1) / per;
  endfunction

  function automatic s32_t clamp0(s32_t v);
    return (v < 32'sd0) ? 32'sd0 : v;
  endfunction

  function automatic s32_t smax(s32_t a, s32_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nand_tcyc_div.sv
module nand_tcyc_div
  import nand_tcyc_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic signed [31:0] ps_in,
  input  logic [PW-1:0]      period_ns,
  output logic signed [31:0] cyc_out
);
  s32_t per_s;

  always_comb begin
    per_s   = s32_t'({{(32-PW){1'b0}}, period_ns});
    cyc_out = ps_to_cycles(ps_in, per_s);
  end
endmodule

// File: rtl/nand_tcyc_solve.sv
module nand_tcyc_solve
  import nand_tcyc_pkg::*;
(
  input  logic [NCONV-1:0][31:0] cyc_vec,
  input  logic signed [31:0]     turn_cyc,
  output logic signed [31:0]     rs,
  output logic signed [31:0]     rst,
  output logic signed [31:0]     rh,
  output logic signed [31:0]     ta,
  output logic signed [31:0]     ws,
  output logic signed [31:0]     wst,
  output logic signed [31:0]     wh
);
  s32_t c [NCONV];

  always_comb begin
    for (int i = 0; i < NCONV; i++) c[i] = $signed(cyc_vec[i]);

    rs  = clamp0(c[C_CLR] - 32'sd1);
    rst = clamp0(smax(c[C_REA], c[C_RP]) - 32'sd1);
    rst = smax(rst, c[C_CEA] - 32'sd2 - rs);
    rh  = clamp0(c[C_RHLD] - 32'sd1);
    rh  = smax(rh, c[C_RC] - 32'sd3 - rs - rst);
    ta  = clamp0(smax(turn_cyc, c[C_CHZ]) - 32'sd1);

    ws  = clamp0(smax(smax(c[C_CLS], c[C_ALS]), c[C_CS]) - 32'sd1);
    wst = clamp0(c[C_WP] - 32'sd1);
    wst = smax(wst, c[C_DS] - 32'sd2 - ws);
    wh  = clamp0(smax(smax(c[C_CLH], c[C_ALH]), smax(c[C_CH], c[C_DH])) - 32'sd1);
    wh  = smax(wh, c[C_WC] - 32'sd2 - ws - wst);
  end
endmodule

// File: rtl/nand_tcyc_calc.sv
module nand_tcyc_calc
  import nand_tcyc_pkg::*;
#(
  parameter int PW       = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4,
  parameter int TURN_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PW-1:0]       period_ns,
  input  logic signed [31:0]  cle_to_re_ps,
  input  logic signed [31:0]  re_access_ps,
  input  logic signed [31:0]  re_pulse_ps,
  input  logic signed [31:0]  ce_access_ps,
  input  logic signed [31:0]  ce_hiz_ps,
  input  logic signed [31:0]  rd_cycle_ps,
  input  logic signed [31:0]  re_hiz_ps,
  input  logic signed [31:0]  cle_setup_ps,
  input  logic signed [31:0]  ale_setup_ps,
  input  logic signed [31:0]  ce_setup_ps,
  input  logic signed [31:0]  we_pulse_ps,
  input  logic signed [31:0]  data_setup_ps,
  input  logic signed [31:0]  cle_hold_ps,
  input  logic signed [31:0]  ale_hold_ps,
  input  logic signed [31:0]  ce_hold_ps,
  input  logic signed [31:0]  data_hold_ps,
  input  logic signed [31:0]  wr_cycle_ps,
  output logic                busy,
  output logic                done,
  output logic [SETUP_W-1:0]  rd_setup,
  output logic [STROBE_W-1:0] rd_strobe,
  output logic [HOLD_W-1:0]   rd_hold,
  output logic [TURN_W-1:0]   turnaround,
  output logic [SETUP_W-1:0]  wr_setup,
  output logic [STROBE_W-1:0] wr_strobe,
  output logic [HOLD_W-1:0]   wr_hold,
  output logic                overflow
);
  localparam int SW       = $clog2(NSTEP);
  localparam int SETUP_MX = (1 << SETUP_W) - 1;
  localparam int STRB_MX  = (1 << STROBE_W) - 1;
  localparam int HOLD_MX  = (1 << HOLD_W) - 1;
  localparam int TURN_MX  = (1 << TURN_W) - 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(NSTEP - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t                 state_q;
  logic [SW-1:0]          step_q;
  logic [NCONV-1:0][31:0] cyc_q;
  s32_t                   operand, div_cyc, per_s;
  s32_t                   rs, rst, rh, ta, ws, wst, wh;
  logic                   accept, last_step, ovf_any;

  assign busy      = (state_q == ST_RUN);
  assign accept    = (state_q == ST_IDLE) && start;
  assign last_step = busy && (step_q == LAST_STEP);
  assign per_s     = s32_t'({{(32-PW){1'b0}}, period_ns});

  // One operand per step into the shared divider.
  always_comb begin
    unique case (step_q)
      5'd0:    operand = cle_to_re_ps;
      5'd1:    operand = re_access_ps + SU_MARGIN_PS;
      5'd2:    operand = re_pulse_ps;
      5'd3:    operand = ce_access_ps + SU_MARGIN_PS;
      5'd4:    operand = HD_MARGIN_PS - ce_hiz_ps;
      5'd5:    operand = rd_cycle_ps;
      5'd6:    operand = ce_hiz_ps;
      5'd7:    operand = cle_setup_ps;
      5'd8:    operand = ale_setup_ps;
      5'd9:    operand = ce_setup_ps;
      5'd10:   operand = we_pulse_ps;
      5'd11:   operand = data_setup_ps;
      5'd12:   operand = cle_hold_ps;
      5'd13:   operand = ale_hold_ps;
      5'd14:   operand = ce_hold_ps;
      5'd15:   operand = data_hold_ps;
      5'd16:   operand = wr_cycle_ps;
      default: operand = re_hiz_ps - (rh + 32'sd1) * per_s * 32'sd1000;
    endcase
  end

  nand_tcyc_div #(.PW(PW)) u_div (
    .ps_in     (operand),
    .period_ns (period_ns),
    .cyc_out   (div_cyc)
  );

  nand_tcyc_solve u_solve (
    .cyc_vec  (cyc_q),
    .turn_cyc (div_cyc),
    .rs       (rs),
    .rst      (rst),
    .rh       (rh),
    .ta       (ta),
    .ws       (ws),
    .wst      (wst),
    .wh       (wh)
  );

  assign ovf_any = (rs > SETUP_MX) || (rst > STRB_MX) || (rh > HOLD_MX) ||
                   (ta > TURN_MX)  || (ws > SETUP_MX) || (wst > STRB_MX) ||
                   (wh > HOLD_MX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      cyc_q      <= '0;
      done       <= 1'b0;
      rd_setup   <= '0;
      rd_strobe  <= '0;
      rd_hold    <= '0;
      turnaround <= '0;
      wr_setup   <= '0;
      wr_strobe  <= '0;
      wr_hold    <= '0;
      overflow   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        step_q  <= '0;
      end else if (last_step) begin
        state_q    <= ST_IDLE;
        done       <= 1'b1;
        rd_setup   <= rs[SETUP_W-1:0];
        rd_strobe  <= rst[STROBE_W-1:0];
        rd_hold    <= rh[HOLD_W-1:0];
        turnaround <= ta[TURN_W-1:0];
        wr_setup   <= ws[SETUP_W-1:0];
        wr_strobe  <= wst[STROBE_W-1:0];
        wr_hold    <= wh[HOLD_W-1:0];
        overflow   <= ovf_any;
      end else if (busy) begin
        cyc_q[step_q] <= div_cyc;
        step_q        <= step_q + 1'b1;
      end
    end
  end

  // Input expectation: a period of zero is never used for a run.
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (period_ns != '0)); // R2

  AST_NO_NEG_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> (rs >= 0 && rst >= 0 && rh >= 0 && ta >= 0 &&
                   ws >= 0 && wst >= 0 && wh >= 0)); // R8

  AST_RD_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> (rs + rst + rh >= $signed(cyc_q[C_RC]) - 32'sd3)); // R4

  AST_WR_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> (ws + wst + wh >= $signed(cyc_q[C_WC]) - 32'sd2)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R10

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_setup) && $stable(rd_strobe) && $stable(rd_hold) &&
               $stable(turnaround) && $stable(wr_setup) && $stable(wr_strobe) &&
               $stable(wr_hold) && $stable(overflow))); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step && start) |=> (busy && !done)); // R11

endmodule

// File: tb/tb_nand_tcyc_calc.sv
module tb_nand_tcyc_calc;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int NF = 18;  // period, then 17 timing values in port order

  localparam int VEC [NV][NF] = '{
    '{10, 0,0,0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0},
    '{10, 10000,20000,12000,25000,30000,25000,100000,
          12000,12000,20000,12000,10000, 5000,5000,5000,5000,25000},
    '{7,  10000,20000,12000,25000,30000,25000,100000,
          12000,12000,20000,12000,10000, 5000,5000,5000,5000,25000},
    '{10, 0,0,0,57000,0,100000,0, 0,0,0,0,80000, 0,0,0,0,120000},
    '{20, 0,0,0,0,0,0,0, 0,0,0,2000000,0, 0,0,0,0,0},
    '{3,  4000,9000,6000,15000,50000,300000,5000,
          2500,2500,9000,7000,4000, 1000,1000,3000,2000,40000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] period_ns = 16'd10;
  logic signed [31:0] tv [17];
  logic busy, done, overflow;
  logic [3:0] rd_setup, rd_hold, wr_setup, wr_hold;
  logic [5:0] rd_strobe, wr_strobe;
  logic [1:0] turnaround;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 17; i++) tv[i] = 0;

  nand_tcyc_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ns(period_ns),
    .cle_to_re_ps(tv[0]), .re_access_ps(tv[1]), .re_pulse_ps(tv[2]),
    .ce_access_ps(tv[3]), .ce_hiz_ps(tv[4]), .rd_cycle_ps(tv[5]),
    .re_hiz_ps(tv[6]), .cle_setup_ps(tv[7]), .ale_setup_ps(tv[8]),
    .ce_setup_ps(tv[9]), .we_pulse_ps(tv[10]), .data_setup_ps(tv[11]),
    .cle_hold_ps(tv[12]), .ale_hold_ps(tv[13]), .ce_hold_ps(tv[14]),
    .data_hold_ps(tv[15]), .wr_cycle_ps(tv[16]),
    .busy(busy), .done(done),
    .rd_setup(rd_setup), .rd_strobe(rd_strobe), .rd_hold(rd_hold),
    .turnaround(turnaround), .wr_setup(wr_setup), .wr_strobe(wr_strobe),
    .wr_hold(wr_hold), .overflow(overflow)
  );

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference built from the requirements, with step-wise padding loops.
  function automatic int cyc(int ps, int p);
    int ns = ps / 1000;
    return (ns + p - 1) / p;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic reference(input int v [NF], output int e [8]);
    int p, s, st, h, t, a, b, c;
    p  = v[0];
    s  = mx(cyc(v[1], p) - 1, 0);
    st = mx(mx(cyc(v[2] + 3000, p), cyc(v[3], p)) - 1, 0);
    while (s + st < cyc(v[4] + 3000, p) - 2) st++;
    h  = mx(cyc(1600 - v[5], p) - 1, 0);
    while (s + st + h < cyc(v[6], p) - 3) h++;
    t  = mx(mx(cyc(v[7] - (h + 1) * p * 1000, p), cyc(v[5], p)) - 1, 0);
    e[0] = s; e[1] = st; e[2] = h; e[3] = t;
    a  = mx(mx(mx(cyc(v[8], p), cyc(v[9], p)), cyc(v[10], p)) - 1, 0);
    b  = mx(cyc(v[11], p) - 1, 0);
    while (a + b < cyc(v[12], p) - 2) b++;
    c  = mx(mx(mx(cyc(v[13], p), cyc(v[14], p)), mx(cyc(v[15], p), cyc(v[16], p))) - 1, 0);
    while (a + b + c < cyc(v[17], p) - 2) c++;
    e[4] = a; e[5] = b; e[6] = c;
    e[7] = (s > 15 || st > 63 || h > 15 || t > 3 || a > 15 || b > 63 || c > 15) ? 1 : 0;
  endtask

  task automatic load(input int v [NF]);
    period_ns = v[0][15:0];
    for (int i = 0; i < 17; i++) tv[i] = v[i+1];
  endtask

  // Pulses start, returns falling edges counted until done is seen.
  task automatic run(output int lat, input bool_restart);
    start = 1'b1;
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (bool_restart && lat == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  task automatic compare(input int e [8], string tag);
    check(rd_setup,   e[0] & 15, "R3", {tag, " rd_setup"});
    check(rd_strobe,  e[1] & 63, "R3", {tag, " rd_strobe"});
    check(rd_hold,    e[2] & 15, "R4", {tag, " rd_hold"});
    check(turnaround, e[3] & 3,  "R5", {tag, " turnaround"});
    check(wr_setup,   e[4] & 15, "R6", {tag, " wr_setup"});
    check(wr_strobe,  e[5] & 63, "R6", {tag, " wr_strobe"});
    check(wr_hold,    e[6] & 15, "R7", {tag, " wr_hold"});
    check(overflow,   e[7],      "R9", {tag, " overflow"});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int lat, e [8], v [NF];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done, 0, "R1", "done"); check(busy, 0, "R1", "busy");
    check(overflow, 0, "R1", "overflow");
    check(rd_setup + rd_strobe + rd_hold + turnaround + wr_setup + wr_strobe + wr_hold,
          0, "R1", "phase sum");

    for (int k = 0; k < NV; k++) begin
      for (int j = 0; j < NF; j++) v[j] = VEC[k][j];
      load(v);
      run(lat, 1'b0);
      check(lat, 19, "R10", "latency (18 cycles after accept)");
      reference(v, e);
      compare(e, $sformatf("vec%0d", k));
    end

    // R3/R4/R6/R7 padding case, hand-computed (vector 3)
    for (int j = 0; j < NF; j++) v[j] = VEC[3][j];
    load(v); run(lat, 1'b0);
    check(rd_strobe, 4, "R3", "strobe padded by ce access");
    check(rd_hold,   3, "R4", "hold padded by read cycle");
    check(wr_strobe, 6, "R6", "strobe padded by data setup");
    check(wr_hold,   4, "R7", "hold padded by write cycle");
    check(turnaround, 0, "R8", "negative turnaround clamped");

    // R9 overflow, hand-computed: strobe 99 -> low bits 35
    for (int j = 0; j < NF; j++) v[j] = VEC[4][j];
    load(v); run(lat, 1'b0);
    check(overflow, 1, "R9", "overflow flag");
    check(wr_strobe, 35, "R9", "truncated strobe");

    // R2 all-zero timings give zero phases
    for (int j = 0; j < NF; j++) v[j] = VEC[0][j];
    load(v); run(lat, 1'b0);
    check(rd_setup + rd_strobe + rd_hold + turnaround + wr_setup + wr_strobe + wr_hold,
          0, "R2", "zero timings");

    // R11 start during busy ignored
    for (int j = 0; j < NF; j++) v[j] = VEC[1][j];
    load(v); run(lat, 1'b1);
    check(lat, 19, "R11", "latency with extra start");
    begin
      int extra = 0;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra, 0, "R11", "extra done pulses");
      check(busy, 0, "R11", "busy after run");
    end
    reference(v, e);
    // R10 results held long after done
    compare(e, "held");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule